// File: doc/BRIEF.md
# PWM Output Break and Enable Controller

This block decides, for every complementary PWM channel pair of a timer, whether each of the two pins is driven by the waveform, held at its inactive (idle) level, or released to high impedance. A single master output enable gates all pairs. Two fault inputs can cut that enable with no clock edge involved: a primary fault, whose active level and enable are programmable and which also carries a clock-failure flag, and a second-level fault that is always armed. Software sets and clears the master enable through a small write port. An optional automatic mode sets it again on the next counter update once the faults have gone away.

The control word written through the port holds, from bit 0 upward: master enable command (bit 0), automatic re-arm (bit 1), primary fault polarity (bit 2, 0 = active low, 1 = active high), primary fault enable (bit 3), run-mode off-state select (bit 4), off-state-when-disabled select (bit 5) and a two-bit lock level (bits 7:6). The same layout is returned on the read-back port, with bit 0 showing the live master enable. A lock level is accepted only while the stored level is 0. Level 1 or above freezes bits 1 to 3; level 2 or above also freezes bit 4.

The master enable is tracked by a four-state machine. States: `ST_SOFT_OFF` (disabled by reset or by software), `ST_RUN` (enabled), `ST_HALT_BRK` (disabled by the primary fault), `ST_HALT_BRK2` (disabled by the second-level fault). Transitions: any state goes to `ST_HALT_BRK2` when the second-level fault is present; `ST_RUN`, `ST_SOFT_OFF` and `ST_HALT_BRK` go to `ST_HALT_BRK` when the primary fault is present; `ST_RUN` goes to either halt state at the next edge after a fault pulse shorter than one clock, which is caught by a capture flop; `ST_RUN` goes to `ST_SOFT_OFF` on a write with bit 0 low; the three disabled states go to `ST_RUN` on a write with bit 0 high, or on an update strobe with automatic re-arm set, but only if no fault is present; the disabled states go to `ST_SOFT_OFF` on a write with bit 0 low when no fault is present. The master enable output is high only in `ST_RUN` and while no fault is present, so a fault removes it at once.

Top module: `pwm_brk_ctrl`

## Requirements
- R1: After reset the master enable is 0, the read-back word is 0, every output-enable and idle output is 0 and the fault status is 0.
- R2: A write with bit 0 high and no fault present sets the master enable at that clock edge; then a channel configured as output drives its main pin (oe 1, idle 0) when its main enable is 1 and its complementary pin likewise when its complementary enable is 1.
- R3: The armed primary fault clears the master enable combinationally, with no clock edge; it is active high when polarity is 1 and active low when polarity is 0. A fault pulse shorter than one clock still leaves the master enable cleared after the next edge.
- R4: When the primary fault enable is 0, neither the primary fault pin nor the clock-failure flag changes the master enable; when it is 1 the clock-failure flag clears it like the primary fault.
- R5: A write to the polarity or the primary fault enable bit shows on the read-back port at the write edge but acts on fault detection only from the following clock edge.
- R6: The second-level fault input (active high, always armed) clears the master enable and forces every output-enable and idle output to 0 while it is present and while the state is `ST_HALT_BRK2`.
- R7: With the master enable cleared by the primary fault or by software, a channel configured as output that has at least one of its two enables set drives both pins to idle (oe 1, idle 1) when bit 5 is 1, and releases both (oe 0) when bit 5 is 0.
- R8: With the master enable set, a pin whose own enable is 0 is released when bit 4 is 0, and driven to idle (oe 1, idle 1) when bit 4 is 1 and the other pin of its pair is enabled.
- R9: With automatic re-arm set, an update strobe sets the master enable only when no fault is present; with automatic re-arm clear an update strobe has no effect.
- R10: A write with bit 0 high while an armed fault is present leaves the master enable at 0.
- R11: Once a non-zero lock level is stored, later writes leave bits 1 to 3 and the lock level unchanged; at level 2 or above bit 4 is also unchanged; bits 0 and 5 stay writable.
- R12: A channel not configured as output has all four of its outputs at 0, whatever the master enable and its channel enables.
- R13: The fault status port shows the primary and second-level fault pin levels (bits 0 and 1) through a two-flop synchronizer: a level change shows after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word written on wr_en |
| brk_in | input | 1 | Primary fault pin, polarity programmable |
| brk2_in | input | 1 | Second-level fault pin, active high |
| clk_fail | input | 1 | Clock-failure flag, gated with the primary fault |
| upd_evt | input | 1 | Counter update strobe, one cycle |
| ch_out | input | NCH | Channel configured as output, one bit per pair |
| en_main | input | NCH | Main pin enable per pair |
| en_comp | input | NCH | Complementary pin enable per pair |
| moe | output | 1 | Live master output enable |
| ctrl_rd | output | 8 | Read-back of the control word |
| brk_stat | output | 2 | Synchronized fault pin levels |
| main_oe | output | NCH | Main pin driven by the timer |
| main_idle | output | NCH | Main pin held at its idle level |
| comp_oe | output | NCH | Complementary pin driven by the timer |
| comp_idle | output | NCH | Complementary pin held at its idle level |

## Verification
The main gating function is driven with four fixed channel patterns at once (both pins enabled, main only, complementary only, and an enabled pair that is not an output), so a single sample separates the run pattern, the run pattern with idle drive on disabled pins, the idle-on-disable pattern and the all-released pattern. These are reached through each cause of disablement in turn (primary fault, clock failure, second-level fault, software clear) and each way back (software set, update re-arm, update while a fault is still present), which tells apart states that produce the same master enable but different pin decisions. Directed sequences then probe the one-cycle delay of polarity and enable writes, a fault pulse shorter than a clock, the synchronizer latency and both lock levels.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

    localparam int CTRL_W = 8;
    localparam int LOCK_W = 2;

    localparam int F_MOE  = 0;
    localparam int F_AUTO = 1;
    localparam int F_POL  = 2;
    localparam int F_ENA  = 3;
    localparam int F_OSSR = 4;
    localparam int F_OSSI = 5;
    localparam int F_LOCK = 6;

    localparam logic [LOCK_W-1:0] LOCK_L1 = 2'd1;
    localparam logic [LOCK_W-1:0] LOCK_L2 = 2'd2;

    typedef enum logic [1:0] {
        ST_SOFT_OFF  = 2'd0,
        ST_RUN       = 2'd1,
        ST_HALT_BRK  = 2'd2,
        ST_HALT_BRK2 = 2'd3
    } moe_state_t;

    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic              ossi;
        logic              ossr;
        logic              ena;
        logic              pol;
        logic              auto_en;
    } ctrl_t;

endpackage

// File: rtl/pbe_regs.sv
module pbe_regs
    import pbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             cfg,
    output logic              pol_eff,
    output logic              ena_eff,
    output logic              moe_set_req,
    output logic              moe_clr_req
);

    // Control fields; lock level gates which of them a write may touch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (cfg.lock < LOCK_L1) begin
                cfg.auto_en <= wr_data[F_AUTO];
                cfg.pol     <= wr_data[F_POL];
                cfg.ena     <= wr_data[F_ENA];
                cfg.lock    <= wr_data[F_LOCK +: LOCK_W];
            end
            if (cfg.lock < LOCK_L2) begin
                cfg.ossr <= wr_data[F_OSSR];
            end
            cfg.ossi <= wr_data[F_OSSI];
        end
    end

    // Fault detection uses copies that trail the stored fields by one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_eff <= 1'b0;
            ena_eff <= 1'b0;
        end else begin
            pol_eff <= cfg.pol;
            ena_eff <= cfg.ena;
        end
    end

    assign moe_set_req = wr_en &  wr_data[F_MOE];
    assign moe_clr_req = wr_en & ~wr_data[F_MOE];

    a_r11_lock_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg.lock != '0) |=> $stable(cfg.lock));

    a_r11_lvl1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg.lock >= LOCK_L1) |=>
            ($stable(cfg.auto_en) && $stable(cfg.pol) && $stable(cfg.ena)));

    a_r11_lvl2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg.lock >= LOCK_L2) |=> $stable(cfg.ossr));

endmodule

// File: rtl/pbe_brk_front.sv
module pbe_brk_front #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brk_in,
    input  logic       brk2_in,
    input  logic       clk_fail,
    input  logic       pol_eff,
    input  logic       ena_eff,
    output logic       kill1,
    output logic       kill2,
    output logic       seen1,
    output logic       seen2,
    output logic [1:0] brk_stat
);

    logic [SYNC_N-1:0] sync1_q;
    logic [SYNC_N-1:0] sync2_q;

    // Raw fault levels: no register between the pins and the enable cut.
    assign kill1 = ena_eff & ((brk_in ~^ pol_eff) | clk_fail);
    assign kill2 = brk2_in;

    // Capture flops: set the moment a fault rises, follow it at each edge,
    // so a pulse between two edges is still seen at the next one.
    always_ff @(posedge clk or negedge rst_n or posedge kill1) begin
        if (!rst_n) begin
            seen1 <= 1'b0;
        end else if (kill1) begin
            seen1 <= 1'b1;
        end else begin
            seen1 <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge kill2) begin
        if (!rst_n) begin
            seen2 <= 1'b0;
        end else if (kill2) begin
            seen2 <= 1'b1;
        end else begin
            seen2 <= 1'b0;
        end
    end

    // Status path only: synchronized pin levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= {sync1_q[SYNC_N-2:0], brk_in};
            sync2_q <= {sync2_q[SYNC_N-2:0], brk2_in};
        end
    end

    assign brk_stat = {sync2_q[SYNC_N-1], sync1_q[SYNC_N-1]};

endmodule

// File: rtl/pbe_moe_fsm.sv
module pbe_moe_fsm
    import pbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       moe_set_req,
    input  logic       moe_clr_req,
    input  logic       upd_evt,
    input  logic       auto_en,
    input  logic       kill1,
    input  logic       kill2,
    input  logic       seen1,
    input  logic       seen2,
    output moe_state_t state,
    output logic       moe,
    output logic       halt2
);

    moe_state_t state_nx;
    logic       kill_any;
    logic       arm_ok;

    assign kill_any = kill1 | kill2;
    assign arm_ok   = ~kill_any & (moe_set_req | (upd_evt & auto_en));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SOFT_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (kill2 | seen2) begin
                    state_nx = ST_HALT_BRK2;
                end else if (kill1 | seen1) begin
                    state_nx = ST_HALT_BRK;
                end else if (moe_clr_req) begin
                    state_nx = ST_SOFT_OFF;
                end
            end
            ST_SOFT_OFF, ST_HALT_BRK: begin
                if (kill2) begin
                    state_nx = ST_HALT_BRK2;
                end else if (kill1) begin
                    state_nx = ST_HALT_BRK;
                end else if (arm_ok) begin
                    state_nx = ST_RUN;
                end else if (moe_clr_req) begin
                    state_nx = ST_SOFT_OFF;
                end
            end
            ST_HALT_BRK2: begin
                if (kill_any) begin
                    state_nx = ST_HALT_BRK2;
                end else if (arm_ok) begin
                    state_nx = ST_RUN;
                end else if (moe_clr_req) begin
                    state_nx = ST_SOFT_OFF;
                end
            end
            default: state_nx = ST_SOFT_OFF;
        endcase
    end

    // Outputs: the enable drops as soon as a fault is present.
    always_comb begin
        moe   = (state == ST_RUN) & ~kill_any;
        halt2 = (state == ST_HALT_BRK2) | kill2;
    end

    a_r10_no_arm_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && kill_any) |=> state != ST_RUN);

    a_r9_manual_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !moe_set_req && !auto_en) |=> state != ST_RUN);

    a_r3_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (seen1 || seen2)) |=> state != ST_RUN);

endmodule

// File: rtl/pbe_out_gate.sv
module pbe_out_gate #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           moe,
    input  logic           halt2,
    input  logic           ossr,
    input  logic           ossi,
    input  logic [NCH-1:0] ch_out,
    input  logic [NCH-1:0] en_main,
    input  logic [NCH-1:0] en_comp,
    output logic [NCH-1:0] main_oe,
    output logic [NCH-1:0] main_idle,
    output logic [NCH-1:0] comp_oe,
    output logic [NCH-1:0] comp_idle
);

    for (genvar i = 0; i < NCH; i++) begin : g_pair
        always_comb begin
            main_oe[i]   = 1'b0;
            main_idle[i] = 1'b0;
            comp_oe[i]   = 1'b0;
            comp_idle[i] = 1'b0;
            if (ch_out[i]) begin
                if (moe) begin
                    if (en_main[i]) begin
                        main_oe[i] = 1'b1;
                    end else if (ossr && en_comp[i]) begin
                        main_oe[i]   = 1'b1;
                        main_idle[i] = 1'b1;
                    end
                    if (en_comp[i]) begin
                        comp_oe[i] = 1'b1;
                    end else if (ossr && en_main[i]) begin
                        comp_oe[i]   = 1'b1;
                        comp_idle[i] = 1'b1;
                    end
                end else if (!halt2 && ossi && (en_main[i] || en_comp[i])) begin
                    main_oe[i]   = 1'b1;
                    main_idle[i] = 1'b1;
                    comp_oe[i]   = 1'b1;
                    comp_idle[i] = 1'b1;
                end
            end
        end

        a_r12_released: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_out[i] |-> !(main_oe[i] || comp_oe[i] || main_idle[i] || comp_idle[i]));

        a_r2_main_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (moe && ch_out[i] && en_main[i]) |-> (main_oe[i] && !main_idle[i]));
    end

endmodule

// File: rtl/pwm_brk_ctrl.sv
module pwm_brk_ctrl
    import pbe_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              brk_in,
    input  logic              brk2_in,
    input  logic              clk_fail,
    input  logic              upd_evt,
    input  logic [NCH-1:0]    ch_out,
    input  logic [NCH-1:0]    en_main,
    input  logic [NCH-1:0]    en_comp,
    output logic              moe,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [1:0]        brk_stat,
    output logic [NCH-1:0]    main_oe,
    output logic [NCH-1:0]    main_idle,
    output logic [NCH-1:0]    comp_oe,
    output logic [NCH-1:0]    comp_idle
);

    ctrl_t      cfg;
    logic       pol_eff;
    logic       ena_eff;
    logic       moe_set_req;
    logic       moe_clr_req;
    logic       kill1;
    logic       kill2;
    logic       seen1;
    logic       seen2;
    logic       halt2;
    moe_state_t state;

    pbe_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg         (cfg),
        .pol_eff     (pol_eff),
        .ena_eff     (ena_eff),
        .moe_set_req (moe_set_req),
        .moe_clr_req (moe_clr_req)
    );

    pbe_brk_front #(.SYNC_N(2)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_in   (brk_in),
        .brk2_in  (brk2_in),
        .clk_fail (clk_fail),
        .pol_eff  (pol_eff),
        .ena_eff  (ena_eff),
        .kill1    (kill1),
        .kill2    (kill2),
        .seen1    (seen1),
        .seen2    (seen2),
        .brk_stat (brk_stat)
    );

    pbe_moe_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .moe_set_req (moe_set_req),
        .moe_clr_req (moe_clr_req),
        .upd_evt     (upd_evt),
        .auto_en     (cfg.auto_en),
        .kill1       (kill1),
        .kill2       (kill2),
        .seen1       (seen1),
        .seen2       (seen2),
        .state       (state),
        .moe         (moe),
        .halt2       (halt2)
    );

    pbe_out_gate #(.NCH(NCH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .moe       (moe),
        .halt2     (halt2),
        .ossr      (cfg.ossr),
        .ossi      (cfg.ossi),
        .ch_out    (ch_out),
        .en_main   (en_main),
        .en_comp   (en_comp),
        .main_oe   (main_oe),
        .main_idle (main_idle),
        .comp_oe   (comp_oe),
        .comp_idle (comp_idle)
    );

    assign ctrl_rd = {cfg.lock, cfg.ossi, cfg.ossr, cfg.ena, cfg.pol, cfg.auto_en, moe};

    a_r6_fault2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (halt2 || state == ST_HALT_BRK2) |-> ((main_oe | comp_oe | main_idle | comp_idle) == '0));

    a_r7_no_drive_unless_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe && !cfg.ossi) |-> ((main_oe | comp_oe) == '0));

endmodule

// File: tb/sim_pwm_brk_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_brk_ctrl;

    localparam int NCH = 4;
    localparam int NV  = 19;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_data = 8'h00;
    logic           brk_in = 1'b0;
    logic           brk2_in = 1'b0;
    logic           clk_fail = 1'b0;
    logic           upd_evt = 1'b0;
    logic [NCH-1:0] ch_out  = 4'b0111;
    logic [NCH-1:0] en_main = 4'b1011;
    logic [NCH-1:0] en_comp = 4'b1101;
    logic           moe;
    logic [7:0]     ctrl_rd;
    logic [1:0]     brk_stat;
    logic [NCH-1:0] main_oe, main_idle, comp_oe, comp_idle;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm_brk_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .brk_in(brk_in), .brk2_in(brk2_in), .clk_fail(clk_fail), .upd_evt(upd_evt),
        .ch_out(ch_out), .en_main(en_main), .en_comp(en_comp),
        .moe(moe), .ctrl_rd(ctrl_rd), .brk_stat(brk_stat),
        .main_oe(main_oe), .main_idle(main_idle), .comp_oe(comp_oe), .comp_idle(comp_idle)
    );

    // {wr, data[7:0], brk, brk2, clk_fail, upd, exp_moe, exp {main_oe, main_idle, comp_oe, comp_idle}}
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 8'h0D, 4'b0000, 1'b1, 16'h3050},
        {1'b0, 8'h00, 4'b1000, 1'b0, 16'h0000},
        {1'b0, 8'h00, 4'b0000, 1'b0, 16'h0000},
        {1'b0, 8'h00, 4'b0001, 1'b0, 16'h0000},
        {1'b1, 8'h2F, 4'b0000, 1'b1, 16'h3050},
        {1'b0, 8'h00, 4'b1000, 1'b0, 16'h7777},
        {1'b0, 8'h00, 4'b1001, 1'b0, 16'h7777},
        {1'b0, 8'h00, 4'b0001, 1'b1, 16'h3050},
        {1'b1, 8'h3F, 4'b0000, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b0100, 1'b0, 16'h0000},
        {1'b0, 8'h00, 4'b0000, 1'b0, 16'h0000},
        {1'b1, 8'h3E, 4'b0000, 1'b0, 16'h7777},
        {1'b0, 8'h00, 4'b0001, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b0010, 1'b0, 16'h7777},
        {1'b1, 8'h37, 4'b0000, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b0000, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b0010, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b1000, 1'b1, 16'h7472},
        {1'b0, 8'h00, 4'b0100, 1'b0, 16'h0000}
    };

    function automatic string vtag(int i);
        case (i)
            0, 4:               return "R2";
            1:                  return "R3";
            2, 5, 11:           return "R7";
            3, 6, 7, 12:        return "R9";
            8, 14:              return "R8";
            9, 10, 18:          return "R6";
            13, 16, 17:         return "R4";
            default:            return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        wr_en = 1'b0; wr_data = 8'h00; upd_evt = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        idle_in();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_in();
        brk_in = 1'b0; brk2_in = 1'b0; clk_fail = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 moe", 32'(moe), 32'd0);
        chk("R1 ctrl_rd", 32'(ctrl_rd), 32'h00);
        chk("R1 outputs", 32'({main_oe, main_idle, comp_oe, comp_idle}), 32'h0);
        chk("R1 brk_stat", 32'(brk_stat), 32'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            wr_en    = VEC[i][29];
            wr_data  = VEC[i][28:21];
            brk_in   = VEC[i][20];
            brk2_in  = VEC[i][19];
            clk_fail = VEC[i][18];
            upd_evt  = VEC[i][17];
            cyc();
            chk({vtag(i), " moe"}, 32'(moe), 32'(VEC[i][16]));
            chk({vtag(i), " outs"}, 32'({main_oe, main_idle, comp_oe, comp_idle}), 32'(VEC[i][15:0]));
            if (i == 0 || i == 5 || i == 8) begin
                chk("R12 ch3 released", 32'({main_oe[3], main_idle[3], comp_oe[3], comp_idle[3]}), 32'd0);
            end
        end
        idle_in();
        brk_in = 1'b0; brk2_in = 1'b0; clk_fail = 1'b0;

        // R5 / R3: polarity change takes one more edge; active-low fault
        do_reset();
        wr(8'h0D);
        cyc();
        chk("R2 moe set", 32'(moe), 32'd1);
        wr(8'h09);
        chk("R5 pol delayed moe", 32'(moe), 32'd1);
        chk("R5 readback immediate", 32'(ctrl_rd), 32'h09);
        cyc();
        chk("R3 active low clears", 32'(moe), 32'd0);
        wr(8'h09);
        chk("R10 set ignored in fault", 32'(moe), 32'd0);
        brk_in = 1'b1;
        cyc();
        wr(8'h09);
        chk("R3 released low fault rearm", 32'(moe), 32'd1);

        // R3: sub-cycle pulse on the second-level fault
        brk2_in = 1'b1;
        #0.5;
        chk("R3 immediate cut", 32'(moe), 32'd0);
        brk2_in = 1'b0;
        #0.5;
        chk("R3 pulse gone", 32'(moe), 32'd1);
        @(negedge clk);
        chk("R3 pulse latched", 32'(moe), 32'd0);

        // R13 synchronizer latency
        do_reset();
        brk2_in = 1'b1;
        cyc();
        chk("R13 one edge", 32'(brk_stat), 32'd0);
        cyc();
        chk("R13 two edges", 32'(brk_stat), 32'd2);
        brk2_in = 1'b0;

        // R11 lock level 1
        do_reset();
        brk_in = 1'b1;
        wr(8'h4A);
        chk("R11 lock1 write", 32'(ctrl_rd), 32'h4A);
        wr(8'hBF);
        chk("R11 lock1 frozen", 32'(ctrl_rd), 32'h7B);

        // R11 lock level 2
        do_reset();
        wr(8'h80);
        wr(8'h3F);
        chk("R11 lock2 frozen", 32'(ctrl_rd), 32'hA1);
        chk("R11 ossr kept off", 32'(main_oe), 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule